// File: doc/BRIEF.md
# Masked Interrupt and Serial-Bit Controller

This block sits beside a small processor core and manages its interrupt inputs and a one-bit serial port. It has five request sources. One is non-maskable. One is an edge-latched high-priority source. Two are level-sensitive maskable sources. The last is an external source gated only by the global enable. The block keeps three mask bits, a global interrupt-enable flip-flop, the pending flip-flop for the edge source and the serial output bit.

The core changes this state through a single configuration write word. Mask bits change only when the write carries a mask-load flag. The serial output changes only when the write carries a serial-load flag. One bit of the write word clears the edge-latched request. A status word gives the core the serial input pin, the pending requests, the enable state and the masks.

The core sets and clears the global enable with one-cycle strobes. It signals that it has taken an interrupt with an accept strobe. The block presents the highest-priority eligible source as a valid flag and a source code. Decoding instructions and making the vectored call are left to the core.

Top module: `intmask_ctrl`

## Requirements
- R1: After reset the masks equal RESET_MASK (default all ones), the enable flag, the edge-pending flop and ser_out are 0, and req_valid is 0 while nmi is low.
- R2: A write with wr_data[3]=1 loads the masks from wr_data[2:0] on the next edge. wr_data[2] masks irq_hi, wr_data[1] masks irq_mid and wr_data[0] masks irq_lo. A write with wr_data[3]=0 leaves the masks unchanged.
- R3: A write with wr_data[6]=1 loads ser_out from wr_data[7]. A write with wr_data[6]=0 leaves ser_out unchanged.
- R4: A mask bit of 1 keeps its source from being presented. A mask bit of 0 lets the source through when the enable flag is set.
- R5: ei sets the enable flag on the next edge. di or ack clear it on the next edge, and a clear wins over a simultaneous ei.
- R6: A rising edge on irq_hi sets the pending flop whatever the mask. The flop stays set after the input falls. It is cleared by a write with wr_data[4]=1, or by ack while code 3 is presented.
- R7: irq_mid and irq_lo are level-sensitive. Their pending bits follow the inputs, and their requests drop when the inputs fall.
- R8: nmi is presented whatever the enable flag and the masks.
- R9: Priority runs nmi, irq_hi, irq_mid, irq_lo, irq_ext, with req_code values 4, 3, 2, 1, 0. irq_ext is gated only by the enable flag.
- R10: rd_data bit 7 is ser_in, bit 6 is the irq_hi pending flop, bit 5 is irq_mid, bit 4 is irq_lo, bit 3 is the enable flag, and bits 2..0 are the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration write word |
| ei | input | 1 | Set the global enable |
| di | input | 1 | Clear the global enable |
| ack | input | 1 | Core accepts the presented request |
| nmi | input | 1 | Non-maskable request (level) |
| irq_hi | input | 1 | Edge-latched maskable request |
| irq_mid | input | 1 | Level maskable request |
| irq_lo | input | 1 | Level maskable request |
| irq_ext | input | 1 | External request, gated by the enable only |
| ser_in | input | 1 | Serial input pin |
| rd_data | output | 8 | Status word |
| ser_out | output | 1 | Serial output bit |
| req_valid | output | 1 | A request is presented |
| req_code | output | 3 | Code of the presented source |

## Verification
The bench builds the block with SYNC_STAGES=0 and the default all-ones RESET_MASK. With these values a level change on a falling edge shows up at once on req_valid and req_code, and an irq_hi edge shows up after a single clock edge. This lets every priority, masking and clearing case be checked at an exact cycle. The synchronizer variant is covered only by elaboration and by the properties, which are written to hold for any stage count.

// File: rtl/intmask_pkg.sv
package intmask_pkg;
   localparam int DATA_W = 8;
   localparam int MASK_N = 3;
   localparam int SRC_N  = 5;
   localparam int CODE_W = $clog2(SRC_N);
   // source indices, also the presented codes (higher wins)
   localparam int IX_EXT = 0;
   localparam int IX_LO  = 1;
   localparam int IX_MID = 2;
   localparam int IX_HI  = 3;
   localparam int IX_NMI = 4;
   // mask bit positions
   localparam int MB_LO  = 0;
   localparam int MB_MID = 1;
   localparam int MB_HI  = 2;
   // write word fields
   localparam int WB_MASK_EN = 3;
   localparam int WB_HI_CLR  = 4;
   localparam int WB_SER_EN  = 6;
   localparam int WB_SER_DAT = 7;
   // status word fields
   localparam int RB_IE  = 3;
   localparam int RB_LO  = 4;
   localparam int RB_MID = 5;
   localparam int RB_HI  = 6;
   localparam int RB_SER = 7;
endpackage

// File: rtl/intmask_edge.sv
module intmask_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic clr,
   output logic pend
);
   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= 1'b0;
         pend <= 1'b0;
      end else begin
         prev <= lvl;
         if (lvl && !prev)
            pend <= 1'b1;        // a fresh edge is never lost to a clear
         else if (clr)
            pend <= 1'b0;
      end
   end
endmodule

// File: rtl/intmask_regs.sv
module intmask_regs #(
   parameter int               MASK_N     = 3,
   parameter logic [MASK_N-1:0] RESET_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              mask_en,
   input  logic [MASK_N-1:0] mask_val,
   input  logic              ser_en,
   input  logic              ser_dat,
   input  logic              ei,
   input  logic              di,
   input  logic              ack,
   output logic [MASK_N-1:0] mask,
   output logic              ie,
   output logic              ser_out
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask    <= RESET_MASK;
         ie      <= 1'b0;
         ser_out <= 1'b0;
      end else begin
         if (wr_en && mask_en) mask    <= mask_val;
         if (wr_en && ser_en)  ser_out <= ser_dat;
         if (di || ack)        ie      <= 1'b0;
         else if (ei)          ie      <= 1'b1;
      end
   end
endmodule

// File: rtl/intmask_prio.sv
module intmask_prio #(
   parameter int N  = 5,
   localparam int CW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          valid,
   output logic [CW-1:0] code
);
   always_comb begin
      valid = |req;
      code  = '0;
      for (int i = 0; i < N; i++)
         if (req[i]) code = CW'(i);   // later (higher) index overrides
   end
endmodule

// File: rtl/intmask_ctrl.sv
module intmask_ctrl
   import intmask_pkg::*;
#(
   parameter int                SYNC_STAGES = 0,
   parameter logic [MASK_N-1:0] RESET_MASK  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ei,
   input  logic              di,
   input  logic              ack,
   input  logic              nmi,
   input  logic              irq_hi,
   input  logic              irq_mid,
   input  logic              irq_lo,
   input  logic              irq_ext,
   input  logic              ser_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              ser_out,
   output logic              req_valid,
   output logic [CODE_W-1:0] req_code
);
   initial begin
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES out of range");
      assert (DATA_W == 8 && MASK_N == 3 && SRC_N == 5)
         else $error("field layout needs an 8-bit word, 3 masks, 5 sources");
   end

   logic [SRC_N-1:0]  raw, s, req;
   logic [MASK_N-1:0] mask;
   logic              ie, hi_pend, hi_clr;
   logic              unused_wr_bit;

   assign unused_wr_bit = wr_data[5];

   always_comb begin
      raw         = '0;
      raw[IX_NMI] = nmi;
      raw[IX_HI]  = irq_hi;
      raw[IX_MID] = irq_mid;
      raw[IX_LO]  = irq_lo;
      raw[IX_EXT] = irq_ext;
   end

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign s = raw;
      end else begin : g_sync
         logic [SRC_N-1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) chain[k] <= '0;
            end else begin
               chain[0] <= raw;
               for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
            end
         end
         assign s = chain[SYNC_STAGES-1];
      end
   endgenerate

   intmask_regs #(.MASK_N(MASK_N), .RESET_MASK(RESET_MASK)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .mask_en  (wr_data[WB_MASK_EN]),
      .mask_val (wr_data[MASK_N-1:0]),
      .ser_en   (wr_data[WB_SER_EN]),
      .ser_dat  (wr_data[WB_SER_DAT]),
      .ei       (ei),
      .di       (di),
      .ack      (ack),
      .mask     (mask),
      .ie       (ie),
      .ser_out  (ser_out)
   );

   assign hi_clr = (wr_en && wr_data[WB_HI_CLR]) ||
                   (ack && req_valid && req_code == CODE_W'(IX_HI));

   intmask_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (s[IX_HI]),
      .clr   (hi_clr),
      .pend  (hi_pend)
   );

   always_comb begin
      req         = '0;
      req[IX_NMI] = s[IX_NMI];
      req[IX_HI]  = ie && hi_pend    && !mask[MB_HI];
      req[IX_MID] = ie && s[IX_MID]  && !mask[MB_MID];
      req[IX_LO]  = ie && s[IX_LO]   && !mask[MB_LO];
      req[IX_EXT] = ie && s[IX_EXT];
   end

   intmask_prio #(.N(SRC_N)) u_prio (
      .req   (req),
      .valid (req_valid),
      .code  (req_code)
   );

   always_comb begin
      rd_data               = '0;
      rd_data[RB_SER]       = ser_in;
      rd_data[RB_HI]        = hi_pend;
      rd_data[RB_MID]       = s[IX_MID];
      rd_data[RB_LO]        = s[IX_LO];
      rd_data[RB_IE]        = ie;
      rd_data[MASK_N-1:0]   = mask;
   end
endmodule

// File: rtl/intmask_ctrl_chk.sv
module intmask_ctrl_chk
   import intmask_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              ei,
   input logic              di,
   input logic              ack,
   input logic [DATA_W-1:0] rd_data,
   input logic              ser_out,
   input logic              req_valid,
   input logic [CODE_W-1:0] req_code
);
   logic unused_chk_bits;
   assign unused_chk_bits = ^{wr_data[5:4]};

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[WB_MASK_EN] |=> rd_data[MASK_N-1:0] == $past(wr_data[MASK_N-1:0])); // R2
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_data[WB_MASK_EN]) |=> $stable(rd_data[MASK_N-1:0])); // R2
   AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[WB_SER_EN] |=> ser_out == $past(wr_data[WB_SER_DAT])); // R3
   AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_data[WB_SER_EN]) |=> $stable(ser_out)); // R3
   AST_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      di || ack |=> !rd_data[RB_IE]); // R5
   AST_IE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ei && !di && !ack |=> rd_data[RB_IE]); // R5
   AST_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_code == CODE_W'(IX_HI) |-> !rd_data[MB_HI] && rd_data[RB_HI]); // R4
   AST_NMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !rd_data[RB_IE] |-> req_code == CODE_W'(IX_NMI)); // R8
   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_code <= CODE_W'(IX_NMI)); // R9
endmodule

bind intmask_ctrl intmask_ctrl_chk u_chk (.*);

// File: tb/sim_intmask_ctrl.sv
module sim_intmask_ctrl;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 0, ei = 0, di = 0, ack = 0;
   logic [7:0] wr_data = '0;
   logic       nmi = 0, irq_hi = 0, irq_mid = 0, irq_lo = 0, irq_ext = 0, ser_in = 0;
   logic [7:0] rd_data;
   logic       ser_out, req_valid;
   logic [2:0] req_code;
   int         n_run = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   intmask_ctrl #(.SYNC_STAGES(0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ei(ei), .di(di), .ack(ack), .nmi(nmi), .irq_hi(irq_hi),
      .irq_mid(irq_mid), .irq_lo(irq_lo), .irq_ext(irq_ext), .ser_in(ser_in),
      .rd_data(rd_data), .ser_out(ser_out), .req_valid(req_valid), .req_code(req_code)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rq(input logic v, input logic [2:0] c);
      return {v, 4'b0, c};
   endfunction

   task automatic chk_req(input string tag, input logic v, input logic [2:0] c);
      #1;
      chk(tag, {req_valid, 4'b0, req_valid ? req_code : 3'b0}, rq(v, v ? c : 3'b0));
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_data = d;
      @(negedge clk); wr_en = 0; wr_data = '0;
   endtask

   task automatic strobe(input int which);   // 0 ei, 1 di, 2 ack, 3 ei+di
      @(negedge clk);
      ei  = (which == 0 || which == 3);
      di  = (which == 1 || which == 3);
      ack = (which == 2);
      @(negedge clk); ei = 0; di = 0; ack = 0;
   endtask

   task automatic t_reset;
      chk("R1 status after reset", rd_data, 8'h07);
      chk("R1 ser_out after reset", {7'b0, ser_out}, 8'h00);
      chk_req("R1 no request after reset", 0, 0);
   endtask

   task automatic t_mask;
      wr(8'h0D); chk("R2 mask load 101", rd_data, 8'h05);
      wr(8'h02); chk("R2 mask kept when load flag 0", rd_data, 8'h05);
      wr(8'h08); chk("R2 mask load 000", rd_data, 8'h00);
      ser_in = 1; #1; chk("R10 ser_in on bit 7", rd_data, 8'h80);
      ser_in = 0;
   endtask

   task automatic t_serial;
      wr(8'hC0); chk("R3 ser_out loaded 1", {7'b0, ser_out}, 8'h01);
      wr(8'h80); chk("R3 ser_out kept when enable 0", {7'b0, ser_out}, 8'h01);
      wr(8'h40); chk("R3 ser_out loaded 0", {7'b0, ser_out}, 8'h00);
      chk("R3 masks untouched by serial writes", rd_data, 8'h00);
   endtask

   task automatic t_enable;
      strobe(0); chk("R5 ei sets enable", rd_data, 8'h08);
      strobe(1); chk("R5 di clears enable", rd_data, 8'h00);
      strobe(3); chk("R5 di wins over ei", rd_data, 8'h00);
      strobe(0); strobe(2); chk("R5 ack clears enable", rd_data, 8'h00);
   endtask

   task automatic t_edge;
      wr(8'h0F);
      @(negedge clk); irq_hi = 1;
      @(negedge clk); chk("R6 edge latched while masked", rd_data, 8'h47);
      irq_hi = 0;
      @(negedge clk); chk("R6 pending held after input falls", rd_data, 8'h47);
      chk_req("R4 masked edge source not presented", 0, 0);
      wr(8'h10); chk("R6 write bit 4 clears pending", rd_data, 8'h07);
   endtask

   task automatic t_levels;
      wr(8'h08); strobe(0);
      @(negedge clk); irq_mid = 1;
      chk_req("R7 mid level presented", 1, 2);
      chk("R10 mid pending on bit 5", rd_data, 8'h28);
      wr(8'h0A);
      chk_req("R4 mid masked not presented", 0, 0);
      chk("R4 mid still pending while masked", rd_data, 8'h2A);
      irq_mid = 0; #1;
      chk("R7 mid pending follows input", rd_data, 8'h0A);
      wr(8'h08);
      @(negedge clk); irq_lo = 1;
      chk_req("R7 lo level presented", 1, 1);
      irq_lo = 0;
      chk_req("R7 lo request drops with input", 0, 0);
   endtask

   task automatic t_priority;
      @(negedge clk); irq_ext = 1; irq_lo = 1; irq_mid = 1;
      chk_req("R9 mid over lo and ext", 1, 2);
      irq_hi = 1;
      @(negedge clk); chk_req("R9 hi over mid", 1, 3);
      irq_hi = 0; irq_mid = 0;
      chk_req("R9 hi held after inputs fall", 1, 3);
      wr(8'h18);
      chk_req("R9 lo after hi cleared", 1, 1);
      irq_lo = 0;
      chk_req("R9 ext lowest", 1, 0);
      strobe(1);
      chk_req("R9 ext gated by enable", 0, 0);
      irq_ext = 0;
   endtask

   task automatic t_nmi;
      wr(8'h0F);
      @(negedge clk); nmi = 1;
      chk_req("R8 nmi with enable off and masks set", 1, 4);
      strobe(0);
      @(negedge clk); irq_hi = 1;
      @(negedge clk); irq_hi = 0;
      wr(8'h08);
      chk_req("R8 nmi over pending hi", 1, 4);
      nmi = 0;
      chk_req("R9 hi presented once nmi drops", 1, 3);
      wr(8'h1F);
      strobe(1);
   endtask

   task automatic t_ack;
      wr(8'h08); strobe(0);
      @(negedge clk); irq_hi = 1;
      @(negedge clk); irq_hi = 0;
      chk_req("R6 hi presented before ack", 1, 3);
      strobe(2);
      chk("R6 ack clears pending and enable", rd_data, 8'h00);
      chk_req("R6 nothing presented after ack", 0, 0);
   endtask

   initial begin
      #(CLK_P * 20000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_serial();
      t_enable();
      t_edge();
      t_levels();
      t_priority();
      t_nmi();
      t_ack();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule